// File: doc/BRIEF.md
# Conversion Result Queue with Sticky Error Flags

This block is a small first-in, first-out store that sits between a sample sequencer and the register read path. The sequencer pushes one conversion result per push strobe; every access to the single read location issues a pop strobe, which hands back the oldest stored result and frees its slot. Storage is a circular buffer addressed by a write (head) pointer and a read (tail) pointer. Each pointer carries one extra wrap bit, so a full buffer and an empty one never look alike.

For debug, the raw head and tail slot numbers are visible, together with full and empty flags. Two sticky error flags record misuse. Overflow records a push that arrived while the buffer was full; that push is thrown away. Underflow records a pop that arrived while the buffer was empty; that pop returns the previous result again. Each flag stays set until software writes one to its clear input.

Top module: `res_fifo`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, head_o and tail_o are 0, ovf_o and unf_o are 0, and pop_data_o is 0.
- R2: A push while the buffer is not full stores push_data_i in the slot head_o names, and head_o advances by one, modulo DEPTH, on the next cycle.
- R3: A push while full_o is 1 stores nothing and leaves head_o unchanged. On the next cycle ovf_o is 1.
- R4: A pop while the buffer is not empty places the oldest stored entry on pop_data_o on the next cycle, and tail_o advances by one, modulo DEPTH.
- R5: A pop while empty_o is 1 leaves tail_o unchanged and keeps the previous pop_data_o. On the next cycle unf_o is 1.
- R6: full_o is 1 exactly when DEPTH (8) entries are held, and empty_o is 1 exactly when none are held. Both are updated on the cycle after the push or pop that changes the count, and they are never 1 together.
- R7: ovf_o and unf_o stay at 1 until a 1 is applied to ovf_clr_i or unf_clr_i respectively. A clear alone drives the flag to 0 on the next cycle.
- R8: When a clear and a new error event for the same flag fall in the same cycle, the flag is 1 on the next cycle.
- R9: A push and a pop in the same cycle on a buffer that is neither full nor empty are both carried out. head_o and tail_o each advance by one, and full_o and empty_o are unchanged.
- R10: A push and a pop in the same cycle while full: the pop is carried out, the push is discarded, ovf_o is set, and full_o drops to 0.
- R11: A push and a pop in the same cycle while empty: the push is stored, the pop counts as an underflow and keeps the previous pop_data_o, and empty_o drops to 0.
- R12: Results leave in the order they were accepted, including when the pointers wrap past slot DEPTH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| push_i | input | 1 | Push strobe from the sequencer |
| push_data_i | input | DATA_W | Result to store |
| pop_i | input | 1 | Pop strobe from a read of the result location |
| pop_data_o | output | DATA_W | Result returned by the last pop |
| head_o | output | PTR_W | Write slot number |
| tail_o | output | PTR_W | Read slot number |
| full_o | output | 1 | All slots hold results |
| empty_o | output | 1 | No slot holds a result |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| ovf_clr_i | input | 1 | Write-one clear of ovf_o |
| unf_clr_i | input | 1 | Write-one clear of unf_o |

## Verification
Every output of this block comes from a register. The effect of a push, pop or clear is therefore due exactly one rising edge later: the pointers, full and empty, the popped data and both error flags. The bench applies each stimulus just after a falling edge and removes it one full period later, at the next falling edge. At that point it compares every output with a queue model kept in the bench, so each result is read half a cycle after the edge that produced it. Idle cycles between operations show that the sticky flags and the held pop data stay put when nothing drives them.

// File: rtl/res_fifo_pkg.sv
package res_fifo_pkg;

   // Index of each sticky error flag in the flag vector
   typedef enum int unsigned {
      FLG_OVF = 0,
      FLG_UNF = 1
   } flag_idx_e;

   localparam int unsigned NUM_FLAGS = 2;

endpackage

// File: rtl/res_fifo_ptr.sv
// Pointer register with one wrap bit above the slot index
module res_fifo_ptr #(
   parameter int unsigned PTR_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv_i,
   output logic [PTR_W:0] ptr_o
);

   logic [PTR_W:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (adv_i) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   assign ptr_o = ptr_q;

endmodule

// File: rtl/res_fifo_store.sv
// Slot array: one write port, one combinational read port
module res_fifo_store #(
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned DEPTH         = 8,
   parameter int unsigned PTR_W         = 3,
   parameter bit          RESET_STORAGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [PTR_W-1:0]  wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [PTR_W-1:0]  rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   logic [DATA_W-1:0] slot_q [DEPTH];

   for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic sel;
      assign sel = wr_en_i && (wr_addr_i == PTR_W'(s));

      if (RESET_STORAGE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_q[s] <= '0;
            end else if (sel) begin
               slot_q[s] <= wr_data_i;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (sel) begin
               slot_q[s] <= wr_data_i;
            end
         end
      end
   end

   assign rd_data_o = slot_q[rd_addr_i];

endmodule

// File: rtl/res_fifo_sticky.sv
// Sticky flag: set beats clear when both arrive together
module res_fifo_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else begin
         flag_q <= set_i | (flag_q & ~clr_i);
      end
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/res_fifo.sv
module res_fifo #(
   parameter int unsigned DATA_W        = 16,
   parameter int unsigned DEPTH         = 8,
   parameter bit          RESET_STORAGE = 1'b1,
   localparam int unsigned PTR_W        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic [DATA_W-1:0] push_data_i,
   input  logic              pop_i,
   output logic [DATA_W-1:0] pop_data_o,
   output logic [PTR_W-1:0]  head_o,
   output logic [PTR_W-1:0]  tail_o,
   output logic              full_o,
   output logic              empty_o,
   output logic              ovf_o,
   output logic              unf_o,
   input  logic              ovf_clr_i,
   input  logic              unf_clr_i
);

   import res_fifo_pkg::*;

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("res_fifo: DEPTH must be at least 2");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_pow2
      $error("res_fifo: DEPTH must be a power of two");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("res_fifo: DATA_W must be at least 1");
   end

   logic [PTR_W:0]    wr_ptr;
   logic [PTR_W:0]    rd_ptr;
   logic              is_full;
   logic              is_empty;
   logic              do_push;
   logic              do_pop;
   logic [DATA_W-1:0] rd_word;
   logic [DATA_W-1:0] pop_data_q;
   logic [NUM_FLAGS-1:0] flg_set;
   logic [NUM_FLAGS-1:0] flg_clr;
   logic [NUM_FLAGS-1:0] flg_q;

   // Same slot with the wrap bits differing means full
   assign is_empty = (wr_ptr == rd_ptr);
   assign is_full  = (wr_ptr[PTR_W-1:0] == rd_ptr[PTR_W-1:0]) &&
                     (wr_ptr[PTR_W] != rd_ptr[PTR_W]);

   assign do_push = push_i && !is_full;
   assign do_pop  = pop_i  && !is_empty;

   res_fifo_ptr #(.PTR_W(PTR_W)) i_wr_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (do_push),
      .ptr_o (wr_ptr)
   );

   res_fifo_ptr #(.PTR_W(PTR_W)) i_rd_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (do_pop),
      .ptr_o (rd_ptr)
   );

   res_fifo_store #(
      .DATA_W        (DATA_W),
      .DEPTH         (DEPTH),
      .PTR_W         (PTR_W),
      .RESET_STORAGE (RESET_STORAGE)
   ) i_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (do_push),
      .wr_addr_i (wr_ptr[PTR_W-1:0]),
      .wr_data_i (push_data_i),
      .rd_addr_i (rd_ptr[PTR_W-1:0]),
      .rd_data_o (rd_word)
   );

   // Returned word is held until the next successful pop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_data_q <= '0;
      end else if (do_pop) begin
         pop_data_q <= rd_word;
      end
   end

   assign flg_set[FLG_OVF] = push_i && is_full;
   assign flg_set[FLG_UNF] = pop_i  && is_empty;
   assign flg_clr[FLG_OVF] = ovf_clr_i;
   assign flg_clr[FLG_UNF] = unf_clr_i;

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
      res_fifo_sticky i_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (flg_set[f]),
         .clr_i  (flg_clr[f]),
         .flag_o (flg_q[f])
      );
   end

   assign pop_data_o = pop_data_q;
   assign head_o     = wr_ptr[PTR_W-1:0];
   assign tail_o     = rd_ptr[PTR_W-1:0];
   assign full_o     = is_full;
   assign empty_o    = is_empty;
   assign ovf_o      = flg_q[FLG_OVF];
   assign unf_o      = flg_q[FLG_UNF];

endmodule

// File: rtl/res_fifo_chk.sv
module res_fifo_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned PTR_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_i,
   input logic              pop_i,
   input logic [DATA_W-1:0] pop_data_o,
   input logic [PTR_W-1:0]  head_o,
   input logic [PTR_W-1:0]  tail_o,
   input logic              full_o,
   input logic              empty_o,
   input logic              ovf_o,
   input logic              unf_o,
   input logic              ovf_clr_i,
   input logic              unf_clr_i
);

   assert_full_empty_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(full_o && empty_o));

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && full_o) |=> ($stable(head_o) && ovf_o));

   assert_underflow_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && empty_o) |=> ($stable(tail_o) && $stable(pop_data_o) && unf_o));

   assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !ovf_clr_i) |=> ovf_o);

   assert_unf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_o && !unf_clr_i) |=> unf_o);

   assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_clr_i && !(push_i && full_o)) |=> !ovf_o);

   assert_unf_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (unf_clr_i && pop_i && empty_o) |=> unf_o);

   assert_both_ops_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !full_o && !empty_o) |=>
         ($stable(full_o) && $stable(empty_o) &&
          head_o == PTR_W'($past(head_o) + 1'b1) &&
          tail_o == PTR_W'($past(tail_o) + 1'b1)));

endmodule

bind res_fifo res_fifo_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W)) i_res_fifo_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_i     (push_i),
   .pop_i      (pop_i),
   .pop_data_o (pop_data_o),
   .head_o     (head_o),
   .tail_o     (tail_o),
   .full_o     (full_o),
   .empty_o    (empty_o),
   .ovf_o      (ovf_o),
   .unf_o      (unf_o),
   .ovf_clr_i  (ovf_clr_i),
   .unf_clr_i  (unf_clr_i)
);

// File: tb/test_res_fifo.sv
module test_res_fifo;

   localparam int unsigned DW = 16;
   localparam int unsigned DP = 8;
   localparam int unsigned PW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          push_i = 1'b0;
   logic [DW-1:0] push_data_i = '0;
   logic          pop_i = 1'b0;
   logic [DW-1:0] pop_data_o;
   logic [PW-1:0] head_o;
   logic [PW-1:0] tail_o;
   logic          full_o;
   logic          empty_o;
   logic          ovf_o;
   logic          unf_o;
   logic          ovf_clr_i = 1'b0;
   logic          unf_clr_i = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Bench model
   logic [DW-1:0] mq[$];
   int            e_head = 0;
   int            e_tail = 0;
   logic [DW-1:0] e_data = '0;
   bit            e_ovf  = 1'b0;
   bit            e_unf  = 1'b0;

   always #4 clk = ~clk;

   res_fifo #(.DATA_W(DW), .DEPTH(DP)) i_res_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .push_i      (push_i),
      .push_data_i (push_data_i),
      .pop_i       (pop_i),
      .pop_data_o  (pop_data_o),
      .head_o      (head_o),
      .tail_o      (tail_o),
      .full_o      (full_o),
      .empty_o     (empty_o),
      .ovf_o       (ovf_o),
      .unf_o       (unf_o),
      .ovf_clr_i   (ovf_clr_i),
      .unf_clr_i   (unf_clr_i)
   );

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "head_o",     32'(head_o),     32'(e_head));
      chk(req, "tail_o",     32'(tail_o),     32'(e_tail));
      chk(req, "full_o",     32'(full_o),     32'(mq.size() == DP));
      chk(req, "empty_o",    32'(empty_o),    32'(mq.size() == 0));
      chk(req, "pop_data_o", 32'(pop_data_o), 32'(e_data));
      chk(req, "ovf_o",      32'(ovf_o),      32'(e_ovf));
      chk(req, "unf_o",      32'(unf_o),      32'(e_unf));
   endtask

   // One cycle of stimulus, applied at a falling edge, checked at the next
   task automatic op(input bit ps, input logic [DW-1:0] d, input bit pp,
                     input bit oc, input bit uc, input string req);
      bit was_full  = (mq.size() == DP);
      bit was_empty = (mq.size() == 0);
      push_i = ps; push_data_i = d; pop_i = pp;
      ovf_clr_i = oc; unf_clr_i = uc;
      if (pp && !was_empty) begin
         e_data = mq.pop_front();
         e_tail = (e_tail + 1) % DP;
      end
      if (ps && !was_full) begin
         mq.push_back(d);
         e_head = (e_head + 1) % DP;
      end
      e_ovf = (ps && was_full) || (e_ovf && !oc);
      e_unf = (pp && was_empty) || (e_unf && !uc);
      @(negedge clk);
      push_i = 1'b0; pop_i = 1'b0; ovf_clr_i = 1'b0; unf_clr_i = 1'b0;
      chk_all(req);
   endtask

   task automatic t_reset();
      chk_all("R1");
   endtask

   task automatic t_fill_drain();
      for (int i = 0; i < DP; i++) op(1'b1, DW'(16'h0100 + i), 1'b0, 1'b0, 1'b0, "R2");
      chk("R6", "full after fill", 32'(full_o), 32'd1);
      op(1'b1, 16'h0BAD, 1'b0, 1'b0, 1'b0, "R3");
      for (int i = 0; i < DP; i++) op(1'b0, '0, 1'b1, 1'b0, 1'b0, "R4");
      chk("R12", "last word in order", 32'(pop_data_o), 32'h0107);
      chk("R6", "empty after drain", 32'(empty_o), 32'd1);
   endtask

   task automatic t_underflow();
      op(1'b0, '0, 1'b1, 1'b0, 1'b0, "R5");
      op(1'b0, '0, 1'b0, 1'b0, 1'b0, "R7");
   endtask

   task automatic t_sticky();
      op(1'b0, '0, 1'b0, 1'b1, 1'b0, "R7");
      op(1'b0, '0, 1'b1, 1'b0, 1'b1, "R8");
      op(1'b0, '0, 1'b0, 1'b0, 1'b1, "R7");
      op(1'b0, '0, 1'b0, 1'b0, 1'b0, "R7");
   endtask

   task automatic t_simul_wrap();
      for (int i = 0; i < 3; i++) op(1'b1, DW'(16'h0200 + i), 1'b0, 1'b0, 1'b0, "R2");
      op(1'b1, 16'h0203, 1'b1, 1'b0, 1'b0, "R9");
      chk("R9", "popped oldest", 32'(pop_data_o), 32'h0200);
      for (int i = 4; i < 9; i++) op(1'b1, DW'(16'h0200 + i), 1'b0, 1'b0, 1'b0, "R12");
      chk("R6", "full across wrap", 32'(full_o), 32'd1);
      op(1'b1, 16'h0EEE, 1'b1, 1'b0, 1'b0, "R10");
      chk("R10", "ovf from full push", 32'(ovf_o), 32'd1);
      op(1'b0, '0, 1'b0, 1'b1, 1'b0, "R7");
      for (int i = 0; i < DP - 1; i++) op(1'b0, '0, 1'b1, 1'b0, 1'b0, "R12");
      chk("R12", "last word after wrap", 32'(pop_data_o), 32'h0208);
   endtask

   task automatic t_empty_both();
      op(1'b1, 16'h0333, 1'b1, 1'b0, 1'b0, "R11");
      chk("R11", "unf on empty pop", 32'(unf_o), 32'd1);
      op(1'b0, '0, 1'b1, 1'b0, 1'b1, "R11");
      chk("R11", "stored word returned", 32'(pop_data_o), 32'h0333);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_fill_drain();
      t_underflow();
      t_sticky();
      t_simul_wrap();
      t_empty_both();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule